// File: doc/BRIEF.md
# Programmable Period Watchdog Timer

This block is a watchdog counter that runs on its own slow clock, separate from the system clock that drives its control register. Software picks one of eight power-of-two timeout periods with a 3-bit select field, turns the watchdog on with an enable bit, and keeps it from firing by writing a restart bit at intervals shorter than the chosen period. If the period runs out with no restart and no disable, the block drives a reset pulse of fixed length, in system clocks, toward the CPU. After that pulse the count runs again from zero.

The tick count of the shortest period (nominally 16 ms) is a parameter. Each higher select code doubles it, so code 7 is 128 times the base, nominally 2048 ms. Power-on reset and power-down both force the watchdog off. A restart request crosses to the watchdog clock through a toggle synchronizer, and the timeout event crosses back the same way.

Top module: `wdog_period_timer`

## Requirements
- R1: After power-on reset the control readback is all zero (select 0, watchdog off), rst_pulse is low, and no pulse appears while the watchdog stays off.
- R2: Control register layout: bits [2:0] are the period select, bit 3 is enable, bit 4 is restart. With select code s, a pulse rises between (TICKS_BASE<<s) and (TICKS_BASE<<s)+3 watchdog clocks, plus at most 6 system clocks, after the write that enables the watchdog.
- R3: A write with bit 4 set clears the watchdog count. Restarts issued more often than the period prevent any pulse. Once they stop, a pulse follows within the R2 window.
- R4: The restart bit clears itself and always reads back as 0, while select and enable read back as written.
- R5: Each timeout pulse stays high for exactly PULSE_LEN system clocks.
- R6: After a timeout the count starts again from zero, so a watchdog left running pulses again exactly TICKS_BASE<<s watchdog clocks after the previous pulse.
- R7: Writing enable as 0 stops the count and holds it at zero, and no pulse follows.
- R8: While pwr_down is high the enable bit is cleared and writes are ignored, so no pulse is produced. The watchdog stays off when pwr_down falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock for the control register and the pulse output |
| wd_clk | input | 1 | Independent watchdog tick clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pwr_down | input | 1 | Power-down indication, forces the watchdog off |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 5 | Write data: [2:0] select, [3] enable, [4] restart |
| rd_data | output | 5 | Control readback, bit 4 always 0 |
| rst_pulse | output | 1 | Reset pulse toward the CPU |

## Verification
The timeout period is measured for select codes 0, 1, 3 and 7. Because each code doubles the period, a window tighter than a factor of two separates neighbouring codes and exposes a wrong shift or a wrong field position. Back-to-back timeouts with no restart check that the count restarts from zero, since a counter that kept its old value or stopped would give the wrong spacing between pulses. Steady restarts, a disable write partway through a count, and power-down with a write attempted while it is high each separate a count that is truly cleared or held from one that only looks idle: in all three cases a run of ticks well past the period must pass with no pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W    = 5;
  localparam int SEL_W    = 3;
  localparam int SEL_LSB  = 0;
  localparam int EN_BIT   = 3;
  localparam int KICK_BIT = 4;
  localparam int NUM_SEL  = 1 << SEL_W;

  // Ticks in the selected period: base period doubled once per select step.
  function automatic int unsigned period_ticks(input int unsigned base,
                                               input logic [SEL_W-1:0] sel);
    return base << sel;
  endfunction
endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [SEL_W-1:0] sel,
  output logic             en,
  output logic             kick_tgl,
  output logic [REG_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel      <= '0;
      en       <= 1'b0;
      kick_tgl <= 1'b0;
    end else if (pwr_down) begin
      en <= 1'b0;
    end else if (wr_en) begin
      sel <= wr_data[SEL_LSB +: SEL_W];
      en  <= wr_data[EN_BIT];
      if (wr_data[KICK_BIT]) kick_tgl <= ~kick_tgl;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[SEL_LSB +: SEL_W] = sel;
    rd_data[EN_BIT] = en;
  end
endmodule

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter
  import wdog_pkg::*;
#(
  parameter int TICKS_BASE = 1000,
  parameter int CNT_W      = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  input  logic             kick_s,
  output logic [CNT_W-1:0] cnt,
  output logic             restart,
  output logic             expire,
  output logic             tmo_tgl
);
  logic             kick_d;
  logic [CNT_W-1:0] last_tick;

  assign restart   = kick_s ^ kick_d;
  assign last_tick = CNT_W'(period_ticks(TICKS_BASE, sel) - 1);
  assign expire    = run && !restart && (cnt >= last_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kick_d  <= 1'b0;
      cnt     <= '0;
      tmo_tgl <= 1'b0;
    end else begin
      kick_d <= kick_s;
      if (!run || restart) begin
        cnt <= '0;
      end else if (expire) begin
        cnt     <= '0;
        tmo_tgl <= ~tmo_tgl;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_pulse_gen.sv
module wdog_pulse_gen #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_s,
  output logic pulse
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic          tgl_d;
  logic [PW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_d <= 1'b0;
      left  <= '0;
    end else begin
      tgl_d <= tgl_s;
      if (tgl_s ^ tgl_d)   left <= PW'(PULSE_LEN);
      else if (left != '0) left <= left - 1'b1;
    end
  end

  assign pulse = (left != '0);
endmodule

// File: rtl/wdog_period_timer.sv
module wdog_period_timer
  import wdog_pkg::*;
#(
  parameter int TICKS_BASE = 1000,
  parameter int PULSE_LEN  = 16
) (
  input  logic             sys_clk,
  input  logic             wd_clk,
  input  logic             por_n,
  input  logic             pwr_down,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             rst_pulse
);
  localparam int CNT_W = $clog2(TICKS_BASE << (NUM_SEL - 1));

  logic [SEL_W-1:0] sel_sys, sel_wd;
  logic             en_sys, kick_tgl_sys;
  logic             wd_rst_n, wd_run, kick_wd;
  logic             wd_restart, wd_expire, tmo_tgl_wd, tmo_tgl_sys;
  logic [CNT_W-1:0] wd_cnt;

  wdog_ctrl_reg u_reg (
    .clk(sys_clk), .rst_n(por_n), .pwr_down(pwr_down),
    .wr_en(wr_en), .wr_data(wr_data),
    .sel(sel_sys), .en(en_sys), .kick_tgl(kick_tgl_sys), .rd_data(rd_data)
  );

  // Reset for the watchdog domain: asynchronous assert, synchronous release.
  wdog_sync #(.W(1)) u_wd_rst (
    .clk(wd_clk), .rst_n(por_n), .d(1'b1), .q(wd_rst_n)
  );

  // Select and enable only change under software control, far slower than a tick.
  wdog_sync #(.W(SEL_W + 1)) u_cfg_sync (
    .clk(wd_clk), .rst_n(wd_rst_n),
    .d({en_sys, sel_sys}), .q({wd_run, sel_wd})
  );

  wdog_sync #(.W(1)) u_kick_sync (
    .clk(wd_clk), .rst_n(wd_rst_n), .d(kick_tgl_sys), .q(kick_wd)
  );

  wdog_tick_counter #(.TICKS_BASE(TICKS_BASE), .CNT_W(CNT_W)) u_cnt (
    .clk(wd_clk), .rst_n(wd_rst_n), .run(wd_run), .sel(sel_wd),
    .kick_s(kick_wd), .cnt(wd_cnt), .restart(wd_restart),
    .expire(wd_expire), .tmo_tgl(tmo_tgl_wd)
  );

  wdog_sync #(.W(1)) u_tmo_sync (
    .clk(sys_clk), .rst_n(por_n), .d(tmo_tgl_wd), .q(tmo_tgl_sys)
  );

  wdog_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(sys_clk), .rst_n(por_n), .tgl_s(tmo_tgl_sys), .pulse(rst_pulse)
  );
endmodule

// File: rtl/wdog_period_timer_chk.sv
module wdog_period_timer_chk
  import wdog_pkg::*;
#(
  parameter int PULSE_LEN = 16,
  parameter int CNT_W     = 17
) (
  input logic             sys_clk,
  input logic             wd_clk,
  input logic             por_n,
  input logic             pwr_down,
  input logic [REG_W-1:0] rd_data,
  input logic             rst_pulse,
  input logic             wd_run,
  input logic             wd_restart,
  input logic             wd_expire,
  input logic [CNT_W-1:0] wd_cnt
);
  localparam int HW = $clog2(PULSE_LEN + 2);
  logic [HW-1:0] hi_len;

  always_ff @(posedge sys_clk or negedge por_n) begin
    if (!por_n)         hi_len <= '0;
    else if (rst_pulse) hi_len <= hi_len + 1'b1;
    else                hi_len <= '0;
  end

  // R5
  pulse_max_len_chk: assert property (@(posedge sys_clk) disable iff (!por_n)
    rst_pulse |-> hi_len < HW'(PULSE_LEN));

  // R5
  pulse_exact_len_chk: assert property (@(posedge sys_clk) disable iff (!por_n)
    (!rst_pulse && hi_len != '0) |-> hi_len == HW'(PULSE_LEN));

  // R4
  kick_reads_zero_chk: assert property (@(posedge sys_clk) disable iff (!por_n)
    rd_data[KICK_BIT] == 1'b0);

  // R8
  pwrdn_disables_chk: assert property (@(posedge sys_clk) disable iff (!por_n)
    pwr_down |=> !rd_data[EN_BIT]);

  // R7
  idle_count_zero_chk: assert property (@(posedge wd_clk) disable iff (!por_n)
    !wd_run |=> wd_cnt == '0);

  // R3
  restart_clears_chk: assert property (@(posedge wd_clk) disable iff (!por_n)
    wd_restart |=> wd_cnt == '0);

  // R6
  expire_wraps_chk: assert property (@(posedge wd_clk) disable iff (!por_n)
    wd_expire |=> wd_cnt == '0);
endmodule

bind wdog_period_timer wdog_period_timer_chk #(
  .PULSE_LEN(PULSE_LEN), .CNT_W(CNT_W)
) u_chk (
  .sys_clk(sys_clk), .wd_clk(wd_clk), .por_n(por_n), .pwr_down(pwr_down),
  .rd_data(rd_data), .rst_pulse(rst_pulse), .wd_run(wd_run),
  .wd_restart(wd_restart), .wd_expire(wd_expire), .wd_cnt(wd_cnt)
);

// File: tb/test_wdog_period_timer.sv
`timescale 1ns/1ps
module test_wdog_period_timer;
  localparam int TICKS   = 8;
  localparam int PULSE   = 6;
  localparam int TSYS    = 8;
  localparam int TWD     = 40;
  localparam int W_EN    = 8;
  localparam int W_KICK  = 16;

  logic       sys_clk = 1'b0;
  logic       wd_clk  = 1'b0;
  logic       por_n   = 1'b0;
  logic       pwr_down = 1'b0;
  logic       wr_en   = 1'b0;
  logic [4:0] wr_data = '0;
  logic [4:0] rd_data;
  logic       rst_pulse;

  int checks   = 0;
  int failures = 0;
  int rises    = 0;
  logic pulse_d = 1'b0;

  always #(TSYS/2) sys_clk = ~sys_clk;
  always #(TWD/2)  wd_clk  = ~wd_clk;

  wdog_period_timer #(.TICKS_BASE(TICKS), .PULSE_LEN(PULSE)) i_wdog_period_timer (
    .sys_clk(sys_clk), .wd_clk(wd_clk), .por_n(por_n), .pwr_down(pwr_down),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .rst_pulse(rst_pulse)
  );

  always @(posedge sys_clk) begin
    pulse_d <= rst_pulse;
    if (rst_pulse && !pulse_d) rises <= rises + 1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] d);
    @(negedge sys_clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge sys_clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_wd(input int n);
    repeat (n * (TWD / TSYS)) @(negedge sys_clk);
  endtask

  // Waits at negedges for rst_pulse high; returns the time or -1 on limit.
  task automatic wait_rise(input int limit_cyc, output longint t);
    t = -1;
    for (int i = 0; i < limit_cyc; i++) begin
      @(negedge sys_clk);
      if (rst_pulse) begin t = longint'($time); return; end
    end
  endtask

  task automatic go_idle();
    wr(5'd0);
    wait_wd(12);
  endtask

  task automatic t_reset();
    check(rd_data == 5'd0, "R1 readback after reset", rd_data, 0);
    check(rst_pulse == 1'b0, "R1 pulse low after reset", rst_pulse, 0);
    begin
      int r0 = rises;
      wait_wd(200);
      check(rises == r0, "R1 no pulse while off", rises - r0, 0);
    end
  endtask

  task automatic t_period(input int sel);
    longint t0, t1, t2, lo, hi, term;
    int hi_cyc;
    term = longint'(TICKS) << sel;
    go_idle();
    @(negedge sys_clk);
    t0 = longint'($time) + TSYS;
    wr(5'(W_EN | sel));
    check(rd_data == 5'(W_EN | sel), "R4 select and enable read back", rd_data, W_EN | sel);
    wait_rise(int'((term + 10) * TWD / TSYS), t1);
    lo = term * TWD;
    hi = (term + 3) * TWD + 6 * TSYS;
    check(t1 >= 0 && (t1 - t0) >= lo && (t1 - t0) <= hi,
          $sformatf("R2 period sel=%0d lo=%0d hi=%0d", sel, lo, hi), t1 - t0, lo);
    hi_cyc = 0;
    while (rst_pulse && hi_cyc < 100) begin hi_cyc++; @(negedge sys_clk); end
    check(hi_cyc == PULSE, "R5 pulse width", hi_cyc, PULSE);
    wait_rise(int'((term + 10) * TWD / TSYS), t2);
    check(t2 >= 0 && (t2 - t1) >= term * TWD - TSYS && (t2 - t1) <= term * TWD + TSYS,
          $sformatf("R6 pulse spacing sel=%0d", sel), t2 - t1, term * TWD);
    go_idle();
  endtask

  task automatic t_restart();
    longint t1;
    int r0;
    go_idle();
    wr(5'(W_EN | 1));
    r0 = rises;
    for (int k = 0; k < 20; k++) begin
      wait_wd(6);
      wr(5'(W_EN | W_KICK | 1));
    end
    check(rises == r0, "R3 restarts hold off pulse", rises - r0, 0);
    check(rd_data == 5'(W_EN | 1), "R4 restart bit reads 0", rd_data, W_EN | 1);
    wait_rise(200, t1);
    check(t1 >= 0, "R3 pulse after restarts stop", t1, 1);
    go_idle();
  endtask

  task automatic t_disable();
    int r0;
    go_idle();
    r0 = rises;
    wr(5'(W_EN));
    wait_wd(4);
    wr(5'd0);
    wait_wd(60);
    check(rises == r0, "R7 disable stops timeout", rises - r0, 0);
    check(rd_data[3] == 1'b0, "R7 enable reads 0", rd_data[3], 0);
  endtask

  task automatic t_pwrdn();
    int r0;
    go_idle();
    r0 = rises;
    wr(5'(W_EN));
    wait_wd(3);
    @(negedge sys_clk); pwr_down = 1'b1;
    @(negedge sys_clk);
    check(rd_data[3] == 1'b0, "R8 power-down clears enable", rd_data[3], 0);
    wr(5'(W_EN | 2));
    check(rd_data == 5'd0, "R8 write ignored in power-down", rd_data, 0);
    wait_wd(60);
    check(rises == r0, "R8 no pulse in power-down", rises - r0, 0);
    @(negedge sys_clk); pwr_down = 1'b0;
    wait_wd(60);
    check(rises == r0 && rd_data[3] == 1'b0, "R8 stays off after power-down", rises - r0, 0);
  endtask

  initial begin
    #(200000 * TSYS - 100);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5 * TWD + 3);
    por_n = 1'b1;
    wait_wd(4);
    t_reset();
    t_period(0);
    t_period(1);
    t_period(3);
    t_period(7);
    t_restart();
    t_disable();
    t_pwrdn();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule